// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the control unit of a multi-cycle processor datapath that shares one memory, one ALU and a set of holding registers across the steps of each instruction. It is a Moore machine: every control pin is a function of the current state register alone. The opcode input only chooses the next state. Every instruction goes through the same fetch step and then the same decode step. After that comes a short sequence for its class, one to three cycles long. The last step of each sequence returns to fetch.

Five instruction classes are supported: load word, store word, register-to-register ALU, branch-if-equal and jump. An opcode that matches none of them ends the instruction right after decode. Every cycle, the surrounding datapath applies the control pins to its multiplexers and register enables. The opcode is driven from the instruction register, which is loaded at the end of fetch. The block has no streaming interface. All pins are plain control levels, so back-pressure does not apply. A datapath that must wait for memory would have to hold the clock enable of the whole processor.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it rises, the outputs show the fetch step. Reset is asynchronous and also abandons an instruction that is part-way through.
- R2: Fetch drives `mem_rd`=1, `ir_load`=1, `pc_wr`=1, `alu_a_sel`=0 (PC), `alu_b_sel`=1 (constant 4), `alu_op`=0 (add) and `pc_src`=0 (ALU result). The next cycle is always decode, which drives `alu_a_sel`=0, `alu_b_sel`=3 (immediate shifted left two) and `alu_op`=0.
- R3: Opcode 6'h23 (load) takes 5 cycles: fetch, decode, then address (`alu_a_sel`=1, `alu_b_sel`=2 sign-extended immediate, `alu_op`=0), then read (`mem_rd`=1, `addr_sel_data`=1), then write-back (`reg_wr`=1, `wb_from_mem`=1, `dst_from_rd`=0).
- R4: Opcode 6'h2B (store) takes 4 cycles: fetch, decode, the same address step as R3, then write (`mem_wr`=1, `addr_sel_data`=1).
- R5: Opcode 6'h00 (register ALU) takes 4 cycles: fetch, decode, execute (`alu_a_sel`=1, `alu_b_sel`=0 register B, `alu_op`=2 function-field driven), then write-back (`reg_wr`=1, `dst_from_rd`=1, `wb_from_mem`=0).
- R6: Opcode 6'h04 (branch if equal) takes 3 cycles. Its third step drives `alu_a_sel`=1, `alu_b_sel`=0, `alu_op`=1 (subtract), `pc_wr_br`=1 and `pc_src`=1 (ALUOut).
- R7: Opcode 6'h02 (jump) takes 3 cycles. Its third step drives `pc_wr`=1 and `pc_src`=2 (jump address).
- R8: Any other opcode returns from decode straight to fetch, so the instruction takes 2 cycles.
- R9: The opcode is examined only in decode and, for loads and stores, in the address step. A change of opcode in any other state does not alter the sequence.
- R10: Every control field that a state does not use is driven 0. No state asserts both `mem_rd` and `mem_wr`. No state asserts `reg_wr` together with a memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset to fetch |
| opcode | input | 6 | Opcode field of the instruction register |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |
| addr_sel_data | output | 1 | Memory address from ALUOut (1) or PC (0) |
| ir_load | output | 1 | Instruction register load enable |
| reg_wr | output | 1 | Register file write enable |
| wb_from_mem | output | 1 | Write-back data from memory data register (1) or ALUOut (0) |
| dst_from_rd | output | 1 | Destination register from rd field (1) or rt field (0) |
| alu_a_sel | output | 1 | ALU A operand: register A (1) or PC (0) |
| alu_b_sel | output | 2 | ALU B operand: 0 reg B, 1 constant 4, 2 sign-ext imm, 3 shifted imm |
| alu_op | output | 2 | ALU operation: 0 add, 1 subtract, 2 from function field |
| pc_src | output | 2 | PC source: 0 ALU result, 1 ALUOut, 2 jump address |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_br | output | 1 | PC write qualified by the ALU zero flag |

## Verification
The hardest situation to reach is a change of opcode partway through an instruction. In a working processor the opcode comes from a register that only changes at fetch. R9 therefore needs a bench that deliberately rewrites the opcode pin in the execute, memory and write-back states. A second case is a reset that arrives partway through a sequence. The bench uses seeded random opcodes, including unmapped values. It scrambles the opcode after the point where the class is decided. It also aborts a load with a reset in its address step, and expects fetch outputs at once and a clean sequence afterwards.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

  localparam int OPC_W     = 6;
  localparam int SEL_W     = 2;
  localparam int N_CLASSES = 5;

  typedef enum logic [3:0] {
    ST_FETCH   = 4'd0,
    ST_DECODE  = 4'd1,
    ST_ADDR    = 4'd2,
    ST_RD      = 4'd3,
    ST_RD_WB   = 4'd4,
    ST_WR      = 4'd5,
    ST_EXEC    = 4'd6,
    ST_EXEC_WB = 4'd7,
    ST_BRANCH  = 4'd8,
    ST_JUMP    = 4'd9
  } state_e;

  // class index doubles as bit position in the classifier hit vector
  typedef enum logic [2:0] {
    CL_LOAD   = 3'd0,
    CL_STORE  = 3'd1,
    CL_RTYPE  = 3'd2,
    CL_BRANCH = 3'd3,
    CL_JUMP   = 3'd4,
    CL_NONE   = 3'd7
  } iclass_e;

  localparam logic [SEL_W-1:0] BSEL_REG   = 2'd0;
  localparam logic [SEL_W-1:0] BSEL_FOUR  = 2'd1;
  localparam logic [SEL_W-1:0] BSEL_IMM   = 2'd2;
  localparam logic [SEL_W-1:0] BSEL_SHIMM = 2'd3;

  localparam logic [SEL_W-1:0] AOP_ADD   = 2'd0;
  localparam logic [SEL_W-1:0] AOP_SUB   = 2'd1;
  localparam logic [SEL_W-1:0] AOP_FUNCT = 2'd2;

  localparam logic [SEL_W-1:0] PCS_ALU  = 2'd0;
  localparam logic [SEL_W-1:0] PCS_OUT  = 2'd1;
  localparam logic [SEL_W-1:0] PCS_JUMP = 2'd2;

  typedef struct packed {
    logic             mem_rd;
    logic             mem_wr;
    logic             addr_sel_data;
    logic             ir_load;
    logic             reg_wr;
    logic             wb_from_mem;
    logic             dst_from_rd;
    logic             alu_a_sel;
    logic [SEL_W-1:0] alu_b_sel;
    logic [SEL_W-1:0] alu_op;
    logic [SEL_W-1:0] pc_src;
    logic             pc_wr;
    logic             pc_wr_br;
  } ctrl_t;

endpackage

// File: rtl/mc_op_classify.sv
module mc_op_classify
  import mc_ctrl_pkg::*;
#(
  parameter int             OW        = OPC_W,
  parameter logic [OW-1:0]  OP_LOAD   = 6'h23,
  parameter logic [OW-1:0]  OP_STORE  = 6'h2B,
  parameter logic [OW-1:0]  OP_RTYPE  = 6'h00,
  parameter logic [OW-1:0]  OP_BRANCH = 6'h04,
  parameter logic [OW-1:0]  OP_JUMP   = 6'h02
) (
  input  logic [OW-1:0] opcode,
  output iclass_e       iclass
);

  localparam logic [N_CLASSES*OW-1:0] OP_TABLE =
    {OP_JUMP, OP_BRANCH, OP_RTYPE, OP_STORE, OP_LOAD};

  logic [N_CLASSES-1:0] hit;

  for (genvar g = 0; g < N_CLASSES; g++) begin : g_match
    assign hit[g] = (opcode == OP_TABLE[g*OW +: OW]);
  end

  always_comb begin
    iclass = CL_NONE;
    for (int i = N_CLASSES - 1; i >= 0; i--) begin
      if (hit[i]) iclass = iclass_e'(i[2:0]);
    end
  end

endmodule

// File: rtl/mc_next_state.sv
module mc_next_state
  import mc_ctrl_pkg::*;
(
  input  state_e  cur,
  input  iclass_e iclass,
  output state_e  nxt
);

  always_comb begin
    nxt = ST_FETCH;
    unique case (cur)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        unique case (iclass)
          CL_LOAD, CL_STORE: nxt = ST_ADDR;
          CL_RTYPE:          nxt = ST_EXEC;
          CL_BRANCH:         nxt = ST_BRANCH;
          CL_JUMP:           nxt = ST_JUMP;
          default:           nxt = ST_FETCH;
        endcase
      end
      ST_ADDR:    nxt = (iclass == CL_LOAD) ? ST_RD : ST_WR;
      ST_RD:      nxt = ST_RD_WB;
      ST_EXEC:    nxt = ST_EXEC_WB;
      default:    nxt = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_decode.sv
module mc_ctrl_decode
  import mc_ctrl_pkg::*;
(
  input  state_e cur,
  output ctrl_t  ctl
);

  always_comb begin
    ctl = '0;
    unique case (cur)
      ST_FETCH: begin
        ctl.mem_rd    = 1'b1;
        ctl.ir_load   = 1'b1;
        ctl.pc_wr     = 1'b1;
        ctl.alu_b_sel = BSEL_FOUR;
        ctl.alu_op    = AOP_ADD;
        ctl.pc_src    = PCS_ALU;
      end
      ST_DECODE: begin
        ctl.alu_b_sel = BSEL_SHIMM;
        ctl.alu_op    = AOP_ADD;
      end
      ST_ADDR: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_b_sel = BSEL_IMM;
        ctl.alu_op    = AOP_ADD;
      end
      ST_RD: begin
        ctl.mem_rd        = 1'b1;
        ctl.addr_sel_data = 1'b1;
      end
      ST_RD_WB: begin
        ctl.reg_wr      = 1'b1;
        ctl.wb_from_mem = 1'b1;
      end
      ST_WR: begin
        ctl.mem_wr        = 1'b1;
        ctl.addr_sel_data = 1'b1;
      end
      ST_EXEC: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_b_sel = BSEL_REG;
        ctl.alu_op    = AOP_FUNCT;
      end
      ST_EXEC_WB: begin
        ctl.reg_wr      = 1'b1;
        ctl.dst_from_rd = 1'b1;
      end
      ST_BRANCH: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_b_sel = BSEL_REG;
        ctl.alu_op    = AOP_SUB;
        ctl.pc_wr_br  = 1'b1;
        ctl.pc_src    = PCS_OUT;
      end
      ST_JUMP: begin
        ctl.pc_wr  = 1'b1;
        ctl.pc_src = PCS_JUMP;
      end
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mc_ctrl_pkg::*;
#(
  parameter int              OW        = OPC_W,
  parameter logic [OW-1:0]   OP_LOAD   = 6'h23,
  parameter logic [OW-1:0]   OP_STORE  = 6'h2B,
  parameter logic [OW-1:0]   OP_RTYPE  = 6'h00,
  parameter logic [OW-1:0]   OP_BRANCH = 6'h04,
  parameter logic [OW-1:0]   OP_JUMP   = 6'h02
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [OW-1:0] opcode,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          addr_sel_data,
  output logic          ir_load,
  output logic          reg_wr,
  output logic          wb_from_mem,
  output logic          dst_from_rd,
  output logic          alu_a_sel,
  output logic [1:0]    alu_b_sel,
  output logic [1:0]    alu_op,
  output logic [1:0]    pc_src,
  output logic          pc_wr,
  output logic          pc_wr_br
);

  state_e  st_q;
  state_e  st_d;
  iclass_e iclass;
  ctrl_t   ctl;

  mc_op_classify #(
    .OW(OW), .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE), .OP_RTYPE(OP_RTYPE),
    .OP_BRANCH(OP_BRANCH), .OP_JUMP(OP_JUMP)
  ) u_cls (
    .opcode (opcode),
    .iclass (iclass)
  );

  mc_next_state u_ns (
    .cur    (st_q),
    .iclass (iclass),
    .nxt    (st_d)
  );

  mc_ctrl_decode u_dec (
    .cur (st_q),
    .ctl (ctl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_FETCH;
    else        st_q <= st_d;
  end

  assign mem_rd        = ctl.mem_rd;
  assign mem_wr        = ctl.mem_wr;
  assign addr_sel_data = ctl.addr_sel_data;
  assign ir_load       = ctl.ir_load;
  assign reg_wr        = ctl.reg_wr;
  assign wb_from_mem   = ctl.wb_from_mem;
  assign dst_from_rd   = ctl.dst_from_rd;
  assign alu_a_sel     = ctl.alu_a_sel;
  assign alu_b_sel     = ctl.alu_b_sel;
  assign alu_op        = ctl.alu_op;
  assign pc_src        = ctl.pc_src;
  assign pc_wr         = ctl.pc_wr;
  assign pc_wr_br      = ctl.pc_wr_br;

endmodule

// File: rtl/mc_ctrl_fsm_chk.sv
module mc_ctrl_fsm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       addr_sel_data,
  input logic       ir_load,
  input logic       reg_wr,
  input logic       wb_from_mem,
  input logic       dst_from_rd,
  input logic       alu_a_sel,
  input logic [1:0] alu_b_sel,
  input logic [1:0] alu_op,
  input logic [1:0] pc_src,
  input logic       pc_wr,
  input logic       pc_wr_br
);

  AST_FETCH_THEN_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    ir_load |=> (!ir_load && !pc_wr && alu_b_sel == 2'd3 && !alu_a_sel)) else $error("fetch not followed by decode"); // R2

  AST_LOAD_WB_TO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && wb_from_mem) |=> ir_load) else $error("load write-back not followed by fetch"); // R3

  AST_STORE_TO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> ir_load) else $error("store not followed by fetch"); // R4

  AST_READ_TO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && addr_sel_data) |=> (reg_wr && wb_from_mem)) else $error("data read not followed by write-back"); // R3

  AST_EXEC_TO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_op == 2'd2) |=> (reg_wr && dst_from_rd)) else $error("execute not followed by write-back"); // R5

  AST_BRANCH_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr_br |-> (alu_op == 2'd1 && pc_src == 2'd1 && !pc_wr)) else $error("branch step malformed"); // R6

  AST_BRANCH_TO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr_br |=> ir_load) else $error("branch not followed by fetch"); // R6

  AST_JUMP_TO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_src == 2'd2) |-> (pc_wr && !ir_load)) else $error("jump step malformed"); // R7

  AST_NO_RW_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)) else $error("read and write together"); // R10

  AST_NO_REG_MEM_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({mem_rd | mem_wr, reg_wr}) <= 1) else $error("register write with memory access"); // R10

endmodule

bind mc_ctrl_fsm mc_ctrl_fsm_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mem_rd        (mem_rd),
  .mem_wr        (mem_wr),
  .addr_sel_data (addr_sel_data),
  .ir_load       (ir_load),
  .reg_wr        (reg_wr),
  .wb_from_mem   (wb_from_mem),
  .dst_from_rd   (dst_from_rd),
  .alu_a_sel     (alu_a_sel),
  .alu_b_sel     (alu_b_sel),
  .alu_op        (alu_op),
  .pc_src        (pc_src),
  .pc_wr         (pc_wr),
  .pc_wr_br      (pc_wr_br)
);

// File: tb/mc_ctrl_fsm_tb.sv
module mc_ctrl_fsm_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] opcode = 6'h00;
  logic       mem_rd, mem_wr, addr_sel_data, ir_load, reg_wr, wb_from_mem;
  logic       dst_from_rd, alu_a_sel, pc_wr, pc_wr_br;
  logic [1:0] alu_b_sel, alu_op, pc_src;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mc_ctrl_fsm u_dut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_sel_data(addr_sel_data),
    .ir_load(ir_load), .reg_wr(reg_wr), .wb_from_mem(wb_from_mem),
    .dst_from_rd(dst_from_rd), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
    .alu_op(alu_op), .pc_src(pc_src), .pc_wr(pc_wr), .pc_wr_br(pc_wr_br)
  );

  // expected step kinds
  localparam int K_FETCH = 0, K_DEC = 1, K_ADDR = 2, K_RD = 3, K_RDWB = 4,
                 K_WR = 5, K_EXEC = 6, K_EXWB = 7, K_BR = 8, K_JMP = 9;

  // {rd,wr,iord,ir,regwr,m2r,dst,a,b[2],op[2],src[2],pcw,pcwc}
  function automatic logic [16:0] exp_vec(input int k);
    case (k)
      K_FETCH: return {1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd1,2'd0,2'd0,1'b1,1'b0};
      K_DEC:   return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd3,2'd0,2'd0,1'b0,1'b0};
      K_ADDR:  return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'd2,2'd0,2'd0,1'b0,1'b0};
      K_RD:    return {1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,2'd0,2'd0,1'b0,1'b0};
      K_RDWB:  return {1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,2'd0,2'd0,2'd0,1'b0,1'b0};
      K_WR:    return {1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,2'd0,2'd0,1'b0,1'b0};
      K_EXEC:  return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'd0,2'd2,2'd0,1'b0,1'b0};
      K_EXWB:  return {1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,2'd0,2'd0,2'd0,1'b0,1'b0};
      K_BR:    return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'd0,2'd1,2'd1,1'b0,1'b1};
      default: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,2'd0,2'd2,1'b1,1'b0};
    endcase
  endfunction

  // class: 0 load,1 store,2 rtype,3 branch,4 jump,5 none
  function automatic int op_class(input logic [5:0] op);
    case (op)
      6'h23: return 0;
      6'h2B: return 1;
      6'h00: return 2;
      6'h04: return 3;
      6'h02: return 4;
      default: return 5;
    endcase
  endfunction

  function automatic int seq_len(input int c);
    case (c)
      0: return 5;
      1, 2: return 4;
      3, 4: return 3;
      default: return 2;
    endcase
  endfunction

  function automatic int seq_step(input int c, input int k);
    if (k == 0) return K_FETCH;
    if (k == 1) return K_DEC;
    case (c)
      0: return (k == 2) ? K_ADDR : (k == 3) ? K_RD : K_RDWB;
      1: return (k == 2) ? K_ADDR : K_WR;
      2: return (k == 2) ? K_EXEC : K_EXWB;
      3: return K_BR;
      default: return K_JMP;
    endcase
  endfunction

  function automatic string req_of(input int c, input int k);
    if (k <= 1) return "R2";
    case (c)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [16:0] act_vec();
    return {mem_rd, mem_wr, addr_sel_data, ir_load, reg_wr, wb_from_mem, dst_from_rd,
            alu_a_sel, alu_b_sel, alu_op, pc_src, pc_wr, pc_wr_br};
  endfunction

  task automatic check_vec(input string req, input logic [16:0] exp, input string what);
    checks++;
    if (act_vec() !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act_vec(), exp);
    end
  endtask

  // runs one instruction starting at a negedge in fetch; ends at next fetch negedge
  task automatic run_instr(input logic [5:0] op, input bit scramble);
    int c = op_class(op);
    int n = seq_len(c);
    opcode = op;
    for (int k = 0; k < n; k++) begin
      string rq = req_of(c, k);
      // R9: once the class is settled, the opcode pin is scrambled
      if (scramble && ((c <= 1 && k >= 3) || (c >= 2 && k >= 2))) begin
        opcode = 6'($urandom);
        rq = {rq, "/R9"};
      end
      check_vec(rq, exp_vec(seq_step(c, k)), $sformatf("op=%h step=%0d", op, k));
      @(negedge clk);
    end
    // after the last step the machine must be back in fetch
    check_vec((c == 5) ? "R8" : "R2", exp_vec(K_FETCH), $sformatf("op=%h return", op));
  endtask

  initial begin : watchdog
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    logic [5:0] known [5] = '{6'h23, 6'h2B, 6'h00, 6'h04, 6'h02};
    void'($urandom(32'h1c0de));
    // R1: outputs show fetch while reset is held
    repeat (3) @(negedge clk);
    check_vec("R1", exp_vec(K_FETCH), "in reset");
    rst_n = 1'b1;
    check_vec("R1", exp_vec(K_FETCH), "after release");

    // directed: every class once, then unmapped opcodes (R8)
    run_instr(6'h23, 1'b0);
    run_instr(6'h2B, 1'b0);
    run_instr(6'h00, 1'b0);
    run_instr(6'h04, 1'b0);
    run_instr(6'h02, 1'b0);
    run_instr(6'h3F, 1'b0);
    run_instr(6'h22, 1'b0);

    // R9 directed: scramble opcode after decision point
    run_instr(6'h23, 1'b1);
    run_instr(6'h00, 1'b1);
    run_instr(6'h2B, 1'b1);

    // R1: reset abandons a load in its address step
    opcode = 6'h23;
    @(negedge clk); @(negedge clk);
    check_vec("R3", exp_vec(K_ADDR), "before abort");
    rst_n = 1'b0;
    #1;
    check_vec("R1", exp_vec(K_FETCH), "async abort");
    @(negedge clk);
    check_vec("R1", exp_vec(K_FETCH), "abort held");
    rst_n = 1'b1;
    run_instr(6'h04, 1'b0);

    // seeded random mix
    for (int i = 0; i < 300; i++) begin
      logic [5:0] op;
      if (($urandom % 5) == 0) op = 6'($urandom);
      else                      op = known[$urandom % 5];
      run_instr(op, 1'($urandom));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule